// File: doc/BRIEF.md
# Two-Level Virtual Address Translator with Translation Cache

This block turns a 32-bit virtual address into a 34-bit physical address by walking a two-level page table in memory. A small fully associative cache of recent leaf entries sits in front of the walker. An access that hits in the cache is answered in the cycle after it is presented. An access that misses reads one or two page-table entries through a single-outstanding read port and then answers. A successful walk leaves its leaf in the cache.

A requester presents one request at a time as a one-cycle `req_valid` pulse. The request carries the address, the access kind and whether it comes from user privilege. The requester then waits for the one-cycle `done` pulse, which carries either a physical address or a page fault. Software-side control reaches the block through two strobes. `root_wr` loads a new root table page number and `fence` requests a full invalidation. Either one empties the cache.

Top module: `xlt_top`

## Requirements
- R1: After reset `done` and `mem_req` are low, the root page number is zero and the cache holds no entry, so the first request always walks.
- R2: A request that hits in the cache raises `done` in the cycle right after the request cycle and issues no memory read.
- R3: A miss reads the upper entry at root*4096 + va[31:22]*4. If that entry points to a lower table, it next reads the entry at PPN*4096 + va[21:12]*4, where the PPN is entry bits [31:10]. Only one read is outstanding at a time. Each read is a one-cycle `mem_req` pulse, and a 4 KiB leaf gives paddr = {PPN, va[11:0]}.
- R4: An entry at either level with bit 0 (valid) clear ends the walk with `fault` high and `paddr` zero, and no further read is made. Every faulting result reports `paddr` zero.
- R5: An entry is a leaf when bit 1 (read) or bit 3 (execute) is set. An upper-level leaf maps a 4 MiB page with paddr = {PPN[21:10], va[21:0]}. It faults when PPN[9:0] is nonzero.
- R6: An entry with bit 2 (write) set and bit 1 clear faults at either level, and so does a lower-level entry that is valid but not a leaf.
- R7: Access kind 0 (load) needs bit 1, kind 1 (store) needs bit 2 and kind 2 (fetch) needs bit 3. Otherwise the result is a fault, and kind 3 always faults.
- R8: A request with `req_user` high succeeds only if bit 4 (user) of the leaf is set. Supervisor requests ignore bit 4.
- R9: A well-formed leaf is cached even when the access it served was refused, and permissions are checked again on every hit. A walk that ends on an invalid, reserved, misaligned or non-leaf entry caches nothing.
- R10: A `fence` pulse invalidates every cache entry, so the next request to any page walks again.
- R11: A `root_wr` pulse loads `root_ppn_in` as the new root and invalidates every cache entry. Later walks start from the new root.
- R12: When an invalidation and a fill fall in the same cycle, the invalidation wins and the leaf is not cached.
- R13: The cache has TLB_ENTRIES (default 8) slots filled in round-robin order. The fill pointer returns to slot 0 on every invalidation, so the ninth fill after an invalidation replaces the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| req_user | input | 1 | High when the access comes from user privilege |
| root_wr | input | 1 | Load new root page number and invalidate cache |
| root_ppn_in | input | 22 | Root table page number written by `root_wr` |
| fence | input | 1 | Invalidate every cache entry |
| mem_req | output | 1 | One-cycle page-table read strobe |
| mem_addr | output | 34 | Physical byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page-table entry returned by memory |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Result is a page fault (with `done`) |
| paddr | output | 34 | Translated physical address (with `done`) |

## Verification
The checker assumes a requester that never issues a new request before the previous `done`. It also assumes a memory that answers each read exactly once, and only after its `mem_req`. The bench keeps to both assumptions. Its requests are separated by at least one idle cycle after `done`, and its memory model returns one response a fixed number of cycles after each read strobe. Invalidations are raised only between requests, except for the one deliberately placed on the fill cycle of a walk. The page table never maps a 4 KiB page inside a superpage region, so at most one cache slot matches a given address.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int VA_W    = 32;
  localparam int PPN_W   = 22;
  localparam int OFF_W   = 12;
  localparam int VPN_W   = 10;
  localparam int PA_W    = PPN_W + OFF_W;
  localparam int PTE_W   = 32;
  localparam int TAG_W   = 2 * VPN_W;
  localparam int PPN_LSB = 10;
  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int B_U = 4;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_TOP  = 2'd1,
    WK_LEAF = 2'd2
  } wk_st_e;

  typedef struct packed {
    logic             sup;
    logic [TAG_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
    logic             r;
    logic             w;
    logic             x;
    logic             u;
  } xl_ent_t;

  function automatic logic [PA_W-1:0] map_pa(input logic sup,
                                             input logic [PPN_W-1:0] ppn,
                                             input logic [VA_W-1:0] va);
    return sup ? {ppn[PPN_W-1:VPN_W], va[VPN_W+OFF_W-1:0]}
               : {ppn, va[OFF_W-1:0]};
  endfunction

  function automatic logic [PA_W-1:0] ent_addr(input logic [PPN_W-1:0] base,
                                               input logic [VPN_W-1:0] idx);
    return {base, {OFF_W{1'b0}}} + PA_W'({idx, 2'b00});
  endfunction
endpackage

// File: rtl/xlt_perm.sv
module xlt_perm
  import xlt_pkg::*;
(
  input  logic       r,
  input  logic       w,
  input  logic       x,
  input  logic       u,
  input  logic [1:0] kind,
  input  logic       user,
  output logic       ok
);
  logic kind_ok;

  always_comb begin
    case (kind)
      ACC_LOAD:  kind_ok = r;
      ACC_STORE: kind_ok = w;
      ACC_FETCH: kind_ok = x;
      default:   kind_ok = 1'b0;
    endcase
  end

  assign ok = kind_ok && (!user || u);
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb
  import xlt_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [TAG_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic               lk_sup,
  output logic [PPN_W-1:0]   lk_ppn,
  output logic               lk_r,
  output logic               lk_w,
  output logic               lk_x,
  output logic               lk_u,
  input  logic               fill_en,
  input  xl_ent_t            fill_ent,
  output logic [ENTRIES-1:0] valid_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  xl_ent_t            ents [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   rr;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = vld[g] &&
        (ents[g].sup ? (ents[g].tag[TAG_W-1:VPN_W] == lk_vpn[TAG_W-1:VPN_W])
                     : (ents[g].tag == lk_vpn));
    end
  endgenerate

  always_comb begin
    lk_hit = |match;
    lk_sup = 1'b0;
    lk_ppn = '0;
    lk_r   = 1'b0;
    lk_w   = 1'b0;
    lk_x   = 1'b0;
    lk_u   = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_sup = ents[i].sup;
        lk_ppn = ents[i].ppn;
        lk_r   = ents[i].r;
        lk_w   = ents[i].w;
        lk_x   = ents[i].x;
        lk_u   = ents[i].u;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
      rr  <= '0;
    end else if (fill_en) begin
      vld[rr] <= 1'b1;
      rr      <= (rr == LAST) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) ents[rr] <= fill_ent;
  end

  assign valid_o = vld;
endmodule

// File: rtl/xlt_walk.sv
module xlt_walk
  import xlt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic             hit,
  input  logic             hit_sup,
  input  logic [PPN_W-1:0] hit_ppn,
  input  logic             hit_ok,
  output xl_ent_t          leaf_ent,
  output logic [1:0]       leaf_kind,
  output logic             leaf_user,
  input  logic             leaf_ok,
  output logic             fill_en,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  paddr
);
  wk_st_e           st;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       kind_q;
  logic             user_q;
  logic             mem_req_q;
  logic [PA_W-1:0]  mem_addr_q;
  logic             done_q;
  logic             fault_q;
  logic [PA_W-1:0]  paddr_q;

  logic pte_v, pte_bad, pte_leaf, misalign, leaf_good, grant;
  logic unused_pte_bits;

  assign pte_v           = mem_rsp_data[B_V];
  assign unused_pte_bits = ^mem_rsp_data[PPN_LSB-1:B_U+1];

  always_comb begin
    leaf_ent.sup = (st == WK_TOP);
    leaf_ent.tag = va_q[VA_W-1:OFF_W];
    leaf_ent.ppn = mem_rsp_data[PTE_W-1:PPN_LSB];
    leaf_ent.r   = mem_rsp_data[B_R];
    leaf_ent.w   = mem_rsp_data[B_W];
    leaf_ent.x   = mem_rsp_data[B_X];
    leaf_ent.u   = mem_rsp_data[B_U];
  end

  assign pte_bad   = !pte_v || (leaf_ent.w && !leaf_ent.r);
  assign pte_leaf  = leaf_ent.r || leaf_ent.x;
  assign misalign  = (st == WK_TOP) && (|leaf_ent.ppn[VPN_W-1:0]);
  assign leaf_good = (st != WK_IDLE) && !pte_bad && pte_leaf && !misalign;
  assign grant     = leaf_good && leaf_ok;
  assign fill_en   = mem_rsp_valid && leaf_good;
  assign leaf_kind = kind_q;
  assign leaf_user = user_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= WK_IDLE;
      va_q       <= '0;
      kind_q     <= '0;
      user_q     <= 1'b0;
      mem_req_q  <= 1'b0;
      mem_addr_q <= '0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      paddr_q    <= '0;
    end else begin
      done_q    <= 1'b0;
      mem_req_q <= 1'b0;
      case (st)
        WK_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            kind_q <= req_kind;
            user_q <= req_user;
            if (hit) begin
              done_q  <= 1'b1;
              fault_q <= !hit_ok;
              paddr_q <= hit_ok ? map_pa(hit_sup, hit_ppn, req_vaddr) : '0;
            end else begin
              mem_req_q  <= 1'b1;
              mem_addr_q <= ent_addr(root_ppn, req_vaddr[VA_W-1:VA_W-VPN_W]);
              st         <= WK_TOP;
            end
          end
        end
        WK_TOP, WK_LEAF: begin
          if (mem_rsp_valid) begin
            if (st == WK_TOP && !pte_bad && !pte_leaf) begin
              mem_req_q  <= 1'b1;
              mem_addr_q <= ent_addr(leaf_ent.ppn, va_q[VPN_W+OFF_W-1:OFF_W]);
              st         <= WK_LEAF;
            end else begin
              done_q  <= 1'b1;
              fault_q <= !grant;
              paddr_q <= grant ? map_pa(leaf_ent.sup, leaf_ent.ppn, va_q) : '0;
              st      <= WK_IDLE;
            end
          end
        end
        default: st <= WK_IDLE;
      endcase
    end
  end

  assign mem_req  = mem_req_q;
  assign mem_addr = mem_addr_q;
  assign done     = done_q;
  assign fault    = fault_q;
  assign paddr    = paddr_q;
endmodule

// File: rtl/xlt_top.sv
module xlt_top
  import xlt_pkg::*;
#(
  parameter int TLB_ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  input  logic             root_wr,
  input  logic [PPN_W-1:0] root_ppn_in,
  input  logic             fence,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  paddr
);
  logic [PPN_W-1:0]       root_q;
  logic                   flush;
  logic                   hit, hit_sup, hit_r, hit_w, hit_x, hit_u, hit_ok;
  logic [PPN_W-1:0]       hit_ppn;
  xl_ent_t                leaf_ent;
  logic [1:0]             leaf_kind;
  logic                   leaf_user, leaf_ok, fill_en;
  logic [TLB_ENTRIES-1:0] tlb_valid;

  always_ff @(posedge clk) begin
    if (rst)          root_q <= '0;
    else if (root_wr) root_q <= root_ppn_in;
  end

  assign flush = fence || root_wr;

  xlt_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .lk_vpn   (req_vaddr[VA_W-1:OFF_W]),
    .lk_hit   (hit),
    .lk_sup   (hit_sup),
    .lk_ppn   (hit_ppn),
    .lk_r     (hit_r),
    .lk_w     (hit_w),
    .lk_x     (hit_x),
    .lk_u     (hit_u),
    .fill_en  (fill_en),
    .fill_ent (leaf_ent),
    .valid_o  (tlb_valid)
  );

  xlt_perm u_perm_hit (
    .r(hit_r), .w(hit_w), .x(hit_x), .u(hit_u),
    .kind(req_kind), .user(req_user), .ok(hit_ok)
  );

  xlt_perm u_perm_leaf (
    .r(leaf_ent.r), .w(leaf_ent.w), .x(leaf_ent.x), .u(leaf_ent.u),
    .kind(leaf_kind), .user(leaf_user), .ok(leaf_ok)
  );

  xlt_walk u_walk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_kind      (req_kind),
    .req_user      (req_user),
    .root_ppn      (root_q),
    .hit           (hit),
    .hit_sup       (hit_sup),
    .hit_ppn       (hit_ppn),
    .hit_ok        (hit_ok),
    .leaf_ent      (leaf_ent),
    .leaf_kind     (leaf_kind),
    .leaf_user     (leaf_user),
    .leaf_ok       (leaf_ok),
    .fill_en       (fill_en),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (done),
    .fault         (fault),
    .paddr         (paddr)
  );
endmodule

// File: rtl/xlt_chk.sv
module xlt_chk
  import xlt_pkg::*;
#(
  parameter int N = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            mem_req,
  input logic [PA_W-1:0] mem_addr,
  input logic            done,
  input logic            fault,
  input logic [PA_W-1:0] paddr,
  input logic [N-1:0]    tlb_valid
);
  assert_read_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  assert_read_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_no_read_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  assert_fault_zero_pa_R4: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (paddr == '0));

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (tlb_valid == '0));
endmodule

bind xlt_top xlt_chk #(.N(TLB_ENTRIES)) u_xlt_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .done      (done),
  .fault     (fault),
  .paddr     (paddr),
  .tlb_valid (tlb_valid)
);

// File: tb/tb_xlt_top.sv
module tb_xlt_top;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        req_user;
  logic        root_wr;
  logic [21:0] root_ppn_in;
  logic        fence;
  logic        mem_req;
  logic [33:0] mem_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done;
  logic        fault;
  logic [33:0] paddr;

  always #5 clk = ~clk;

  xlt_top dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user), .root_wr(root_wr),
    .root_ppn_in(root_ppn_in), .fence(fence), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault), .paddr(paddr)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] pmem [logic [33:0]];
  logic [33:0] rd_log [$];

  bit          m_vld [8];
  bit          m_sup [8];
  logic [19:0] m_tag [8];
  logic [21:0] m_ppn [8];
  logic [3:0]  m_prm [8];
  int          m_rr;
  logic [21:0] m_root;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [33:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  function automatic bit perm(input logic [3:0] p, input logic [1:0] kind, input bit user);
    bit k;
    case (kind)
      2'd0:    k = p[3];
      2'd1:    k = p[2];
      2'd2:    k = p[1];
      default: k = 1'b0;
    endcase
    return k && (!user || p[0]);
  endfunction

  function automatic logic [33:0] pa_of(input bit sup, input logic [21:0] ppn,
                                        input logic [31:0] va);
    return sup ? {ppn[21:10], va[21:0]} : {ppn, va[11:0]};
  endfunction

  function automatic logic [31:0] mkva(input int v1, input int v0, input int off);
    return {v1[9:0], v0[9:0], off[11:0]};
  endfunction

  function automatic logic [31:0] mkpte(input int ppn, input int flags);
    return {ppn[21:0], flags[9:0]};
  endfunction

  task automatic m_flush();
    for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
    m_rr = 0;
  endtask

  // memory: one response LAT cycles after each read strobe
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req === 1'b1) begin
        logic [33:0] a;
        a = mem_addr;
        rd_log.push_back(a);
        repeat (LAT) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(a);
      end
    end
  end

  task automatic xlate(input string tag, input logic [31:0] va, input logic [1:0] kind,
                       input bit user, input bit fence_hit = 1'b0);
    int lat;
    int hi;
    bit hit, e_fault, fill, f_sup, early_bad, good;
    logic [33:0] e_pa, a;
    logic [31:0] p;
    logic [21:0] f_ppn;
    logic [3:0]  f_p;
    logic [33:0] e_log [$];
    hit = 0; hi = 0; fill = 0; f_sup = 0; f_ppn = '0; f_p = '0;
    for (int i = 7; i >= 0; i--) begin
      if (m_vld[i] && (m_sup[i] ? (m_tag[i][19:10] == va[31:22]) : (m_tag[i] == va[31:12]))) begin
        hit = 1; hi = i;
      end
    end
    if (hit) begin
      lat = 1;
      e_fault = !perm(m_prm[hi], kind, user);
      e_pa = e_fault ? 34'h0 : pa_of(m_sup[hi], m_ppn[hi], va);
    end else begin
      a = {m_root, 12'h0} + {22'h0, va[31:22], 2'b00};
      e_log.push_back(a);
      p = rd(a);
      lat = LAT + 2;
      good = p[0] && !(p[2] && !p[1]);
      if (good && !(p[1] || p[3])) begin
        a = {p[31:10], 12'h0} + {22'h0, va[21:12], 2'b00};
        e_log.push_back(a);
        p = rd(a);
        lat = 2 * LAT + 3;
        good = p[0] && !(p[2] && !p[1]);
        if (good && (p[1] || p[3])) begin fill = 1; f_sup = 0; end
      end else if (good && p[19:10] == 10'h0) begin
        fill = 1; f_sup = 1;
      end
      if (fill) begin
        f_ppn = p[31:10];
        f_p = {p[1], p[2], p[3], p[4]};
        e_fault = !perm(f_p, kind, user);
        e_pa = e_fault ? 34'h0 : pa_of(f_sup, f_ppn, va);
      end else begin
        e_fault = 1; e_pa = 34'h0;
      end
    end
    @(negedge clk);
    rd_log.delete();
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_user = user;
    early_bad = 0;
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      fence = fence_hit && (c == lat - 1);
      if (c < lat && done !== 1'b0) early_bad = 1;
    end
    fence = 1'b0;
    chk(tag, "done timing {early,done}", 64'({early_bad, done}), 64'({1'b0, 1'b1}));
    chk(tag, "fault", 64'(fault), 64'(e_fault));
    chk(tag, "paddr", 64'(paddr), 64'(e_pa));
    chk(tag, "read count", 64'(rd_log.size()), 64'(e_log.size()));
    for (int i = 0; i < e_log.size() && i < rd_log.size(); i++)
      chk(tag, "read address", 64'(rd_log[i]), 64'(e_log[i]));
    if (fence_hit) m_flush();
    else if (fill) begin
      m_vld[m_rr] = 1; m_sup[m_rr] = f_sup; m_tag[m_rr] = va[31:12];
      m_ppn[m_rr] = f_ppn; m_prm[m_rr] = f_p;
      m_rr = (m_rr + 1) % 8;
    end
  endtask

  task automatic do_fence();
    @(negedge clk); fence = 1'b1;
    @(negedge clk); fence = 1'b0;
    m_flush();
  endtask

  task automatic set_root(input logic [21:0] r);
    @(negedge clk); root_wr = 1'b1; root_ppn_in = r;
    @(negedge clk); root_wr = 1'b0;
    m_root = r;
    m_flush();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_user = 1'b0;
    root_wr = 1'b0; root_ppn_in = '0; fence = 1'b0;
    m_flush(); m_root = '0;
    // upper table at page 1
    pmem[34'h1000 + 0*4] = mkpte(2, 'h01);
    pmem[34'h1000 + 1*4] = mkpte('h400, 'h0F);
    pmem[34'h1000 + 2*4] = mkpte('h401, 'h0F);
    pmem[34'h1000 + 4*4] = mkpte('h007, 'h05);
    // lower table at page 2
    pmem[34'h2000 + 0*4] = mkpte('h100, 'h07);
    pmem[34'h2000 + 1*4] = mkpte('h101, 'h13);
    pmem[34'h2000 + 2*4] = mkpte('h102, 'h09);
    pmem[34'h2000 + 4*4] = mkpte('h005, 'h01);
    pmem[34'h2000 + 5*4] = mkpte('h105, 'h05);
    for (int k = 16; k <= 24; k++) pmem[34'h2000 + 34'(k*4)] = mkpte('h200 + k, 'h03);
    // second root at page 3
    pmem[34'h3000] = mkpte(4, 'h01);
    pmem[34'h4000] = mkpte('h300, 'h03);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done after reset", 64'(done), 64'(0));
    chk("R1", "mem_req after reset", 64'(mem_req), 64'(0));

    set_root(22'h1);
    xlate("R1", mkva(0, 0, 'h123), 2'd0, 0);        // empty cache: walks
    xlate("R3", mkva(0, 0, 'h456), 2'd0, 0);        // two-level map, now cached
    xlate("R2", mkva(0, 0, 'h789), 2'd1, 0);        // hit
    xlate("R8", mkva(0, 0, 'h010), 2'd0, 1);        // user, U clear
    xlate("R8", mkva(0, 1, 'h020), 2'd0, 1);        // user, U set
    xlate("R7", mkva(0, 1, 'h030), 2'd1, 1);        // store on read-only
    xlate("R9", mkva(0, 2, 'h040), 2'd0, 0);        // refused load, leaf cached
    xlate("R9", mkva(0, 2, 'h044), 2'd2, 0);        // fetch hits
    xlate("R7", mkva(0, 2, 'h048), 2'd3, 0);        // reserved kind
    xlate("R4", mkva(0, 3, 'h000), 2'd0, 0);        // lower entry invalid
    xlate("R9", mkva(0, 3, 'h000), 2'd0, 0);        // not cached: walks again
    xlate("R4", mkva(3, 0, 'h000), 2'd0, 0);        // upper entry invalid
    xlate("R6", mkva(0, 4, 'h000), 2'd0, 0);        // lower non-leaf
    xlate("R6", mkva(0, 5, 'h000), 2'd1, 0);        // write without read, lower
    xlate("R6", mkva(4, 0, 'h000), 2'd1, 0);        // write without read, upper
    xlate("R5", mkva(1, 5, 'h234), 2'd2, 0);        // superpage
    xlate("R5", mkva(1, 9, 'h0AB), 2'd1, 0);        // superpage hit elsewhere
    xlate("R5", mkva(2, 0, 'h000), 2'd0, 0);        // misaligned superpage
    do_fence();
    xlate("R10", mkva(0, 0, 'h123), 2'd0, 0);       // walks after fence
    xlate("R12", mkva(0, 1, 'h000), 2'd0, 0, 1'b1); // fence on fill cycle
    xlate("R12", mkva(0, 1, 'h004), 2'd0, 0);       // not cached
    do_fence();
    for (int k = 16; k <= 24; k++) xlate("R13", mkva(0, k, 'h100), 2'd0, 0);
    xlate("R13", mkva(0, 17, 'h200), 2'd0, 0);      // second fill survives
    xlate("R13", mkva(0, 16, 'h200), 2'd0, 0);      // first fill replaced
    set_root(22'h3);
    xlate("R11", mkva(0, 0, 'h123), 2'd0, 0);       // new root, new mapping
    xlate("R11", mkva(0, 0, 'h124), 2'd0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule